// File: doc/BRIEF.md
# Transmit Descriptor Ring Reader

This block walks a circular list of two-word transmit descriptors held in system memory. Each descriptor names a buffer (word at offset 0) and carries a control word (offset 4) giving the buffer length, an end-of-frame mark, a CRC-suppression request, a wrap mark and an ownership ("used") flag. The block fetches the buffer bytes over a simple word-wide memory port and delivers them as a byte stream with start, end and abort markers. When a frame finishes, it writes completion status back into the control word of the frame's first descriptor.

Software fills descriptors, clears their used flags and pulses `start`. The walk continues from descriptor to descriptor until one is found still marked used. A `halt` pulse lets the current frame complete, including its status write, and then stops. `busy` stays high for as long as the block is anywhere but idle. The byte stream is valid/ready: a beat is transferred on a clock edge where both `out_valid` and `out_ready` are high. While `out_ready` is low, the offered beat and all its markers are held unchanged. The consumer may hold `out_ready` low for any length of time.

Top module: `tx_ring_reader`

## Requirements
- R1: After reset `busy`, `mem_req` and `out_valid` are low.
- R2: The descriptor with index i sits at `ring_base + 8*i`. Its control word is read first, from offset 4, and its buffer address second, from offset 0. A memory request holds its address, direction and data unchanged until the cycle in which `mem_ack` is high.
- R3: Buffers are word aligned and have a length (control bits 10:0) of at least 1. Their bytes leave in address order, with byte 0 of a word taken from bits 7:0. A beat that is offered while `out_ready` is low is held unchanged.
- R4: `out_sof` marks the first beat of a frame. `out_eof` marks the last byte of a buffer whose control bit 15 is set. The buffers of one frame are joined into a single frame. `out_nocrc` carries bit 16 of the frame's first control word.
- R5: If the descriptor fetched at the start of a frame has bit 31 (used) set, the block goes idle, writes nothing and emits nothing. The next start fetches that same descriptor again.
- R6: After a descriptor whose control bit 30 (wrap) is set, the next fetch is at index 0. Otherwise the index increments.
- R7: After the last beat of a frame is accepted, the block performs one write to the control word of the frame's first descriptor. The value written is the original control word with bit 31 set and bits 29:27 replaced by the status flags.
- R8: If a used descriptor is met before the end-of-frame buffer, the block emits one beat with `out_eof` and `out_abort` set and data 0. It then writes back with bit 27 set and goes idle, with its pointer left on the used descriptor.
- R9: If the block waits for a buffer word with `out_ready` high for `UR_LIMIT` consecutive cycles, bit 28 is set in that frame's write-back.
- R10: A `retry_fail` pulse while a frame is in progress sets bit 29 in that frame's write-back.
- R11: A `halt` pulse while busy lets the current frame finish, including its write-back, and then the block goes idle. A `start` and `halt` together while idle leave the block idle.
- R12: A `start` pulse while busy has no effect on the stream or on memory traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin walking from the current descriptor |
| halt | input | 1 | Stop after the current frame |
| ring_base | input | 32 | Byte address of descriptor 0 |
| retry_fail | input | 1 | Retry limit reached for the current frame |
| busy | output | 1 | High while not idle |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| out_valid | output | 1 | Stream beat offered |
| out_ready | input | 1 | Consumer accepts the beat |
| out_data | output | 8 | Frame byte |
| out_sof | output | 1 | First beat of frame |
| out_eof | output | 1 | Last beat of frame |
| out_abort | output | 1 | Frame cut short, beat carries no data |
| out_nocrc | output | 1 | Frame requests no CRC |

## Verification
The collision that matters most is between a halt request and a start request arriving in the same cycle. The bench drives both together while the block is idle and expects `busy` to stay low. It also raises `halt` partway through a frame, while bytes are still moving. It then checks that the frame completes, that its status is written back, and that the following ready descriptor is left untouched. A behavioural walker in the bench computes, from memory contents alone, the exact beat sequence and write-back words. These are compared against the ports on every clock, under both steady and random back-pressure and under several memory latencies.

// File: rtl/tdr_pkg.sv
package tdr_pkg;
  localparam int WORD_W    = 32;
  localparam int LEN_W     = 11;
  localparam int BIT_LAST  = 15;
  localparam int BIT_NOCRC = 16;
  localparam int BIT_EXH   = 27;
  localparam int BIT_UNDR  = 28;
  localparam int BIT_RETRY = 29;
  localparam int BIT_WRAP  = 30;
  localparam int BIT_USED  = 31;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CTRL, ST_ADDR, ST_DATA, ST_SEND, ST_ABORT, ST_WB
  } tdr_state_e;

  function automatic logic [WORD_W-1:0] tdr_status(input logic [WORD_W-1:0] ctrl,
                                                    input logic ex, input logic ur,
                                                    input logic rt);
    logic [WORD_W-1:0] v;
    v = ctrl;
    v[BIT_USED]  = 1'b1;
    v[BIT_EXH]   = ex;
    v[BIT_UNDR]  = ur;
    v[BIT_RETRY] = rt;
    return v;
  endfunction
endpackage

// File: rtl/tdr_desc_ptr.sv
module tdr_desc_ptr #(
  parameter int IDX_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        advance,
  input  logic        wrap,
  input  logic [31:0] ring_base,
  output logic [31:0] desc_addr
);
  localparam int PAD_W = 32 - IDX_W - 3;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx <= '0;
    else if (advance) idx <= wrap ? '0 : idx + 1'b1;
  end

  assign desc_addr = ring_base + {{PAD_W{1'b0}}, idx, 3'b000};
endmodule

// File: rtl/tdr_byte_lane.sv
module tdr_byte_lane
  import tdr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_len,
  input  logic [LEN_W-1:0]  len,
  input  logic              load_word,
  input  logic [WORD_W-1:0] word_in,
  input  logic              take,
  output logic [7:0]        cur_byte,
  output logic              rem_one,
  output logic              rem_zero,
  output logic              pos_last
);
  localparam int POS_W = $clog2(WORD_W / 8);
  logic [WORD_W-1:0] word_q;
  logic [POS_W-1:0]  pos;
  logic [LEN_W-1:0]  rem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      pos    <= '0;
      rem    <= '0;
    end else begin
      if (load_word) word_q <= word_in;
      if (load_len) begin
        rem <= len;
        pos <= '0;
      end else if (take) begin
        rem <= rem - 1'b1;
        pos <= pos + 1'b1;
      end
    end
  end

  assign cur_byte = word_q[{pos, 3'b000} +: 8];
  assign rem_one  = (rem == LEN_W'(1));
  assign rem_zero = (rem == '0);
  assign pos_last = (pos == {POS_W{1'b1}});
endmodule

// File: rtl/tdr_underrun_watch.sv
module tdr_underrun_watch #(
  parameter int UR_LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic waiting,
  output logic hit
);
  localparam int CNT_W = $clog2(UR_LIMIT + 1);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (!waiting) cnt <= '0;
    else if (!hit) cnt <= cnt + 1'b1;
  end

  assign hit = waiting && (cnt == CNT_W'(UR_LIMIT - 1));
endmodule

// File: rtl/tx_ring_reader.sv
module tx_ring_reader
  import tdr_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int UR_LIMIT = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        halt,
  input  logic [31:0] ring_base,
  input  logic        retry_fail,
  output logic        busy,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        out_sof,
  output logic        out_eof,
  output logic        out_abort,
  output logic        out_nocrc
);
  tdr_state_e state;
  logic [WORD_W-1:0] frame_ctrl, frame_addr, buf_ptr;
  logic cur_last, cur_wrap, in_frame, sent_any;
  logic ur_f, rt_f, ex_f, halt_pend, stop_wb;

  logic [31:0] desc_addr;
  logic [7:0]  lane_byte;
  logic lane_one, lane_zero, lane_pos_last;
  logic load_len, load_word, take, buf_done, ur_hit, waiting;

  assign load_len  = (state == ST_CTRL) && mem_ack && !mem_rdata[BIT_USED];
  assign load_word = (state == ST_DATA) && mem_ack;
  assign take      = (state == ST_SEND) && out_ready;
  assign buf_done  = ((state == ST_ADDR) && mem_ack && lane_zero) ||
                     (take && lane_one);
  assign waiting   = (state == ST_DATA) && out_ready && !mem_ack;

  tdr_desc_ptr #(.IDX_W(IDX_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .advance(buf_done), .wrap(cur_wrap),
    .ring_base(ring_base), .desc_addr(desc_addr)
  );

  tdr_byte_lane u_lane (
    .clk(clk), .rst_n(rst_n), .load_len(load_len), .len(mem_rdata[LEN_W-1:0]),
    .load_word(load_word), .word_in(mem_rdata), .take(take),
    .cur_byte(lane_byte), .rem_one(lane_one), .rem_zero(lane_zero),
    .pos_last(lane_pos_last)
  );

  tdr_underrun_watch #(.UR_LIMIT(UR_LIMIT)) u_ur (
    .clk(clk), .rst_n(rst_n), .waiting(waiting), .hit(ur_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      frame_ctrl <= '0;
      frame_addr <= '0;
      buf_ptr    <= '0;
      cur_last   <= 1'b0;
      cur_wrap   <= 1'b0;
      in_frame   <= 1'b0;
      sent_any   <= 1'b0;
      ur_f       <= 1'b0;
      rt_f       <= 1'b0;
      ex_f       <= 1'b0;
      halt_pend  <= 1'b0;
      stop_wb    <= 1'b0;
    end else begin
      if (state == ST_IDLE) halt_pend <= 1'b0;
      else if (halt) halt_pend <= 1'b1;
      if (ur_hit) ur_f <= 1'b1;
      if (retry_fail && in_frame) rt_f <= 1'b1;

      unique case (state)
        ST_IDLE: if (start && !halt) state <= ST_CTRL;
        ST_CTRL: if (mem_ack) begin
          if (mem_rdata[BIT_USED]) begin
            state <= in_frame ? ST_ABORT : ST_IDLE;
          end else begin
            cur_last <= mem_rdata[BIT_LAST];
            cur_wrap <= mem_rdata[BIT_WRAP];
            if (!in_frame) begin
              frame_ctrl <= mem_rdata;
              frame_addr <= desc_addr;
              in_frame   <= 1'b1;
              sent_any   <= 1'b0;
              ur_f       <= 1'b0;
              rt_f       <= 1'b0;
              ex_f       <= 1'b0;
            end
            state <= ST_ADDR;
          end
        end
        ST_ADDR: if (mem_ack) begin
          buf_ptr <= mem_rdata;
          if (lane_zero) state <= cur_last ? ST_WB : ST_CTRL;
          else           state <= ST_DATA;
        end
        ST_DATA: if (mem_ack) state <= ST_SEND;
        ST_SEND: if (out_ready) begin
          sent_any <= 1'b1;
          if (lane_one) begin
            state <= cur_last ? ST_WB : ST_CTRL;
          end else if (lane_pos_last) begin
            buf_ptr <= buf_ptr + 32'd4;
            state   <= ST_DATA;
          end
        end
        ST_ABORT: if (out_ready) begin
          ex_f    <= 1'b1;
          stop_wb <= 1'b1;
          state   <= ST_WB;
        end
        ST_WB: if (mem_ack) begin
          in_frame <= 1'b0;
          stop_wb  <= 1'b0;
          state    <= (stop_wb || halt_pend) ? ST_IDLE : ST_CTRL;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req = 1'b0;
    mem_we  = 1'b0;
    mem_addr = '0;
    unique case (state)
      ST_CTRL: begin mem_req = 1'b1; mem_addr = desc_addr + 32'd4; end
      ST_ADDR: begin mem_req = 1'b1; mem_addr = desc_addr; end
      ST_DATA: begin mem_req = 1'b1; mem_addr = buf_ptr; end
      ST_WB:   begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = frame_addr + 32'd4; end
      default: ;
    endcase
  end

  assign mem_wdata = (state == ST_WB) ? tdr_status(frame_ctrl, ex_f, ur_f, rt_f) : '0;
  assign busy      = (state != ST_IDLE);
  assign out_valid = (state == ST_SEND) || (state == ST_ABORT);
  assign out_data  = (state == ST_SEND) ? lane_byte : 8'h00;
  assign out_sof   = out_valid && !sent_any;
  assign out_eof   = (state == ST_ABORT) || ((state == ST_SEND) && lane_one && cur_last);
  assign out_abort = (state == ST_ABORT);
  assign out_nocrc = frame_ctrl[BIT_NOCRC];
endmodule

// File: rtl/tdr_checker.sv
module tdr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_ack,
  input logic        out_valid,
  input logic        out_ready,
  input logic [7:0]  out_data,
  input logic        out_sof,
  input logic        out_eof,
  input logic        out_abort
);
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  assert_beat_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sof)
                                && $stable(out_eof) && $stable(out_abort));

  assert_abort_is_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_abort |-> out_valid && out_eof && (out_data == 8'h00));

  assert_wb_marks_used_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[31]);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !out_valid);
endmodule

bind tx_ring_reader tdr_checker u_tdr_checker (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_sof(out_sof), .out_eof(out_eof), .out_abort(out_abort)
);

// File: tb/tb_tx_ring_reader.sv
module tb_tx_ring_reader;
  localparam logic [31:0] BASE = 32'h100;
  localparam logic [31:0] BUFB = 32'h200;
  localparam int UR = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, halt = 1'b0, retry_fail = 1'b0;
  logic busy, mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic out_valid, out_ready = 1'b0, out_sof, out_eof, out_abort, out_nocrc;
  logic [7:0] out_data;

  tx_ring_reader #(.IDX_W(8), .UR_LIMIT(UR)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .halt(halt), .ring_base(BASE),
    .retry_fail(retry_fail), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
    .out_abort(out_abort), .out_nocrc(out_nocrc)
  );

  always #4 clk = ~clk;

  logic [31:0] mem [256];
  logic [11:0] exp_beats[$];
  logic [63:0] exp_wr[$];
  int errors = 0, checks = 0;
  int m_idx = 0, lat = 1, cnt = 0, rnd_ready = 0;
  bit want_first = 0, finished = 0;
  logic [31:0] exp_first;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem[a[9:2]];
  endfunction

  // memory responder and stream monitor, both off the active edge
  always @(negedge clk) begin
    logic [63:0] e;
    logic [11:0] b, act;
    if (rst_n) begin
      out_ready = (rnd_ready == 0) ? 1'b1 : (($urandom % 3) != 0);
      if (mem_ack) begin mem_ack = 1'b0; cnt = 0; end
      if (mem_req) begin
        if (want_first) begin
          chk(mem_addr == exp_first, "R2/R6 first fetch address", {32'd0, mem_addr}, {32'd0, exp_first});
          want_first = 0;
        end
        if (cnt + 1 >= lat) begin
          mem_ack = 1'b1;
          if (mem_we) begin
            if (exp_wr.size() == 0) chk(0, "R7 unexpected write", {mem_addr, mem_wdata}, 64'd0);
            else begin
              e = exp_wr.pop_front();
              chk({mem_addr, mem_wdata} == e, "R7 write-back", {mem_addr, mem_wdata}, e);
            end
            mem[mem_addr[9:2]] = mem_wdata;
          end else mem_rdata = mem[mem_addr[9:2]];
        end else cnt++;
      end
      #1;
      if (out_valid && out_ready) begin
        act = {out_abort, out_eof, out_sof, out_nocrc, out_data};
        if (exp_beats.size() == 0) chk(0, "R3 unexpected beat", {52'd0, act}, 64'd0);
        else begin
          b = exp_beats.pop_front();
          chk(act == b, "R3/R4 beat", {52'd0, act}, {52'd0, b});
        end
      end
    end
  end

  task automatic set_desc(input int i, input int len, input bit last, input bit nocrc);
    logic [31:0] c;
    c = 32'(len) & 32'h7FF;
    c[15] = last; c[16] = nocrc; c[30] = (i == 3);
    mem[(BASE[9:2]) + 2*i]     = BUFB + 32'(i * 128);
    mem[(BASE[9:2]) + 2*i + 1] = c;
  endtask

  task automatic set_used(input int i);
    mem[(BASE[9:2]) + 2*i + 1] = {1'b1, (i == 3), 30'd0};
  endtask

  // behavioural walker: expected beats and write-backs from memory contents
  task automatic model_walk(input int maxf, input bit ur, input bit rt);
    int frames, len;
    bit stop, done, sent, ex;
    logic [31:0] c, fctrl, faddr, a, w, s;
    frames = 0; stop = 0;
    while (!stop && frames != maxf) begin
      c = rd(BASE + 32'(8 * m_idx) + 4);
      if (c[31]) break;
      faddr = BASE + 32'(8 * m_idx); fctrl = c; sent = 0; ex = 0; done = 0;
      while (!done) begin
        c = rd(BASE + 32'(8 * m_idx) + 4);
        if (c[31]) begin
          exp_beats.push_back({1'b1, 1'b1, !sent, fctrl[16], 8'h00});
          ex = 1; stop = 1; done = 1;
        end else begin
          a = rd(BASE + 32'(8 * m_idx));
          len = int'(c[10:0]);
          for (int k = 0; k < len; k++) begin
            w = rd(a + 32'((k / 4) * 4));
            exp_beats.push_back({1'b0, c[15] && (k == len - 1), !sent, fctrl[16], w[8*(k%4) +: 8]});
            sent = 1;
          end
          m_idx = c[30] ? 0 : m_idx + 1;
          if (c[15]) done = 1;
        end
      end
      s = fctrl; s[31] = 1'b1; s[29] = rt; s[28] = ur; s[27] = ex;
      exp_wr.push_back({faddr + 32'd4, s});
      frames++;
    end
  endtask

  task automatic go(input int maxf, input bit ur, input bit rt, input int halt_at,
                    input int retry_at, input int restart_at, input string tag);
    int k;
    exp_first = BASE + 32'(8 * m_idx) + 4;
    model_walk(maxf, ur, rt);
    want_first = 1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    k = 0;
    while (busy && k < 20000) begin
      halt = (k == halt_at); retry_fail = (k == retry_at); start = (k == restart_at);
      @(negedge clk);
      k++;
    end
    halt = 1'b0; retry_fail = 1'b0; start = 1'b0;
    chk(k < 20000, {tag, " goes idle"}, 64'(k), 64'd0);
    chk(exp_beats.size() == 0, {tag, " all beats seen"}, 64'(exp_beats.size()), 64'd0);
    chk(exp_wr.size() == 0, {tag, " all write-backs seen"}, 64'(exp_wr.size()), 64'd0);
    exp_beats.delete(); exp_wr.delete();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'(i) * 32'h9E3779B1 ^ 32'h5A5A0F0F;
    for (int i = 0; i < 4; i++) set_used(i);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    // R1 reset state
    chk(!busy, "R1 busy", 64'(busy), 0);
    chk(!mem_req, "R1 mem_req", 64'(mem_req), 0);
    chk(!out_valid, "R1 out_valid", 64'(out_valid), 0);

    // R5: every descriptor owned by software-side used flag
    go(-1, 0, 0, -1, -1, -1, "R5");
    chk(rd(BASE + 4) == 32'h8000_0000, "R5 desc0 untouched", 64'(rd(BASE + 4)), 64'h8000_0000);

    // single buffer frame
    set_desc(0, 5, 1, 0);
    go(-1, 0, 0, -1, -1, -1, "R7");
    chk(rd(BASE + 4) == 32'h8000_8005, "R7 used set in desc0", 64'(rd(BASE + 4)), 64'h8000_8005);

    // R4/R12: three-buffer frame, nocrc, back-pressure, extra start while busy, then wrap
    lat = 2; rnd_ready = 1;
    set_desc(1, 3, 0, 1); set_desc(2, 6, 0, 0); set_desc(3, 2, 1, 0);
    go(-1, 0, 0, -1, -1, 4, "R12");

    // R6: wrapped to index 0, two frames back to back
    lat = 1; rnd_ready = 0;
    set_desc(0, 7, 1, 0); set_desc(1, 4, 1, 1); set_used(2);
    go(-1, 0, 0, -1, -1, -1, "R6");

    // R8: used descriptor mid-frame
    set_desc(2, 5, 0, 0); set_used(3);
    go(-1, 0, 0, -1, -1, -1, "R8");

    // R9: slow memory with ready consumer
    lat = UR + 4;
    set_desc(3, 9, 1, 0);
    go(-1, 1, 0, -1, -1, -1, "R9");

    // R10: retry limit pulse during frame
    lat = 3; rnd_ready = 1;
    set_desc(0, 40, 1, 0);
    go(-1, 0, 1, -1, 10, -1, "R10");

    // R11: halt mid-frame; following descriptor stays untouched
    lat = 1; rnd_ready = 0;
    set_desc(1, 20, 1, 0); set_desc(2, 6, 1, 0);
    go(1, 0, 0, 5, -1, -1, "R11");
    chk(rd(BASE + 20) == 32'h0000_8006, "R11 next desc untouched", 64'(rd(BASE + 20)), 64'h8006);
    go(-1, 0, 0, -1, -1, -1, "R11 resume");

    // R11: start and halt in the same idle cycle
    @(negedge clk); start = 1'b1; halt = 1'b1;
    @(negedge clk); start = 1'b0; halt = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk(!busy && !mem_req, "R11 start+halt stays idle", 64'(busy), 0);
      @(negedge clk);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL R1 watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule